// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block lets two processors, called side A and side B, pass 32-bit words and doorbell signals to each other. Each side owns a simple register port (valid, write, word address, write data, combinational read data) and an interrupt output. Four one-word channels run in each direction. A word one side stores into one of its outgoing slots appears in the matching incoming slot of the other side, and the flags on the two sides stay linked. The sender's "slot empty" flag drops when the word is written and comes back when the receiver reads the word. The receiver's "word present" flag follows the opposite pattern.

Four doorbells also run in each direction, apart from the data path. A side rings a doorbell by setting a request bit in its control register. The peer sees a pending flag and acknowledges it by writing one to that flag. The acknowledge also clears the requester's bit. Either side can start a unit-wide soft reset. The reset is busy for a fixed number of cycles and returns both sides to their power-on state.

Each side decodes the same word addresses. Outgoing slot n is at byte address 4·n. Incoming slot n is at 0x10 + 4·n. The status word is at 0x20 and the control word is at 0x24. Accesses whose two low address bits are not zero are ignored and read as zero. Reads of the outgoing slots and of unmapped addresses return zero.

Top module: `ipc_msg_unit`

## Requirements
- R1: After the reset input, each side's status word reads 0x00F00000. That means every slot-empty flag is one, and every word-present flag, doorbell-pending flag and the busy flag are zero. Each control word reads 0 and both interrupt outputs are low.
- R2: A write of word D to outgoing slot n (address 4·n) on one side clears that side's slot-empty flag n (status bit 23−n) and sets the peer's word-present flag n (status bit 27−n). A read of the peer's incoming slot n (address 0x10+4·n) then returns D.
- R3: A read of incoming slot n clears that side's word-present flag n and sets the sender's slot-empty flag n again. If the sender writes slot n in the same cycle as the read, the write wins and the flag stays set.
- R4: Both directions behave the same way: the four channels from B to A follow R2 and R3 independently of the four channels from A to B.
- R5: A control-word write with bit 19−n set raises doorbell n. The peer's pending flag (status bit 31−n) goes to one, and the requester's control bit 19−n reads one. Writing zero to that control bit does not withdraw the request.
- R6: Writing one to status bit 31−n clears pending flag n, and with it the peer's request bit 19−n. Writing zero leaves the flag unchanged.
- R7: A side's interrupt output is high exactly when at least one of these holds for some n: slot-empty with control bit 23−n set, word-present with control bit 27−n set, or doorbell-pending with control bit 31−n set.
- R8: A control-word write with bit 5 set starts a soft reset. The rest of that written word is discarded. Status bit 7 reads one on both sides for RST_CYCLES cycles and then zero. At the end, both sides hold the state given in R1, and all slot data reads zero.
- R9: While the soft reset is busy, writes and read side effects on both ports are ignored.
- R10: Writes to incoming slots, writes to status bits other than the pending flags, and accesses with a misaligned address change no flag and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Side A access strobe |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the access cycle |
| a_irq | output | 1 | Side A interrupt |
| b_valid | input | 1 | Side B access strobe |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the access cycle |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets four collisions: a read and a write on the same channel in the same cycle, bus traffic while the soft reset is busy, a doorbell acknowledged with zero bits, and a zero written to a pending request. A design that let the read win the collision would lose a word. One that obeyed bus writes during reset would leave stale flags behind. A wrong acknowledge mask or a retractable request would drop or invent doorbells. Random mixed traffic on both sides is compared against a flag model, so a mirrored bit position or a swapped direction shows up as a wrong status word or interrupt level.

// File: rtl/ipc_mu_pkg.sv
// Shared constants for the messaging unit: channel count, word indices
// and the bit layout of the status and control words.
// Assumes exactly four channels per direction; the bit layout depends on it.
package ipc_mu_pkg;
    localparam int CH = 4;

    localparam int WIDX_SR  = 8;
    localparam int WIDX_CR  = 9;
    localparam int WIDX_RX0 = 4;

    localparam int BIT_RST_REQ  = 5;
    localparam int BIT_RST_BUSY = 7;

    // Bit holding slot-empty (status) or its enable (control) for channel n.
    function automatic int te_pos(input int n);
        return 20 + (CH - 1 - n);
    endfunction
    // Bit holding word-present (status) or its enable (control).
    function automatic int rf_pos(input int n);
        return 24 + (CH - 1 - n);
    endfunction
    // Bit holding doorbell-pending (status) or its enable (control).
    function automatic int gp_pos(input int n);
        return 28 + (CH - 1 - n);
    endfunction
    // Control bit that raises doorbell n toward the peer.
    function automatic int gr_pos(input int n);
        return 16 + (CH - 1 - n);
    endfunction
endpackage

// File: rtl/ipc_mu_chan.sv
// One single-word channel in one direction. It holds the word and a
// "present" flag. The sender's slot-empty view is the inverse of the flag.
// Assumes wr and rd come from the two different sides.
module ipc_mu_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic          full,
    output logic [DW-1:0] data
);
    // Presence flag: the write wins over a same-cycle read; soft reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  full <= 1'b0;
        else if (wr)        full <= 1'b1;
        else if (rd)        full <= 1'b0;
    end

    // Word storage, loaded by the sender and cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  data <= '0;
        else if (wr)        data <= wdata;
    end

    assert_wr_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> full);
    assert_rd_clears_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && !clr) |=> !full);
    assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!full && data == '0));
endmodule

// File: rtl/ipc_mu_bell.sv
// One doorbell in one direction. A single flop serves as the requester's
// request bit and as the receiver's pending flag.
// Assumes req comes from the ringing side and ack from the peer.
module ipc_mu_bell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    input  logic ack,
    output logic pend
);
    // Pending state: a new request wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pend <= 1'b0;
        else if (req)       pend <= 1'b1;
        else if (ack)       pend <= 1'b0;
    end

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req && !clr) |=> !pend);
    assert_req_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr) |=> pend);
endmodule

// File: rtl/ipc_mu_rstseq.sv
// Soft-reset sequencer. A start pulse holds busy for CYC cycles.
// A start pulse that arrives while busy is ignored.
module ipc_mu_rstseq #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Down-counter that runs the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
        else if (start)      cnt <= CW'(CYC);
    end

    assign busy = (cnt != '0);

    assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CW'(1)) |=> !busy);
endmodule

// File: rtl/ipc_mu_side.sv
// One side's register port. It decodes accesses, holds the interrupt
// enables, builds the status and control words and drives the interrupt.
// Channel and doorbell state sit outside this module; it sees them as
// inputs and drives strobes back. Accesses are ignored while busy.
module ipc_mu_side
    import ipc_mu_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic                  valid,
    input  logic                  write,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic                  irq,
    output logic [CH-1:0]         tx_wr,
    output logic [CH-1:0]         rx_rd,
    output logic [CH-1:0]         gir_set,
    output logic [CH-1:0]         gip_ack,
    output logic                  rst_req,
    input  logic [CH-1:0]         tx_full,
    input  logic [CH-1:0]         rx_full,
    input  logic [CH-1:0][DW-1:0] rx_data,
    input  logic [CH-1:0]         gir_q,
    input  logic [CH-1:0]         gip_q
);
    localparam int IW = AW - 2;

    logic [IW-1:0] widx;
    logic          hit, wr_acc, rd_acc, cr_wr;
    logic [CH-1:0] tie, rie, gie;
    logic [DW-1:0] sr, cr;

    // Access qualification: aligned, strobed and not in soft reset.
    always_comb begin
        widx   = addr[AW-1:2];
        hit    = valid && (addr[1:0] == 2'b00);
        wr_acc = hit && write && !busy;
        rd_acc = hit && !write && !busy;
        cr_wr  = wr_acc && (widx == IW'(WIDX_CR));
    end

    // Strobes toward the channels, doorbells and sequencer.
    always_comb begin
        rst_req = cr_wr && wdata[BIT_RST_REQ];
        for (int n = 0; n < CH; n++) begin
            tx_wr[n]   = wr_acc && (widx == IW'(n));
            rx_rd[n]   = rd_acc && (widx == IW'(WIDX_RX0 + n));
            gir_set[n] = cr_wr && !wdata[BIT_RST_REQ] && wdata[gr_pos(n)];
            gip_ack[n] = wr_acc && (widx == IW'(WIDX_SR)) && wdata[gp_pos(n)];
        end
    end

    // Interrupt enables: loaded by a control write without a reset request.
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            tie <= '0;
            rie <= '0;
            gie <= '0;
        end else if (cr_wr && !wdata[BIT_RST_REQ]) begin
            for (int n = 0; n < CH; n++) begin
                tie[n] <= wdata[te_pos(n)];
                rie[n] <= wdata[rf_pos(n)];
                gie[n] <= wdata[gp_pos(n)];
            end
        end
    end

    // Status and control word assembly.
    always_comb begin
        sr = '0;
        cr = '0;
        sr[BIT_RST_BUSY] = busy;
        for (int n = 0; n < CH; n++) begin
            sr[te_pos(n)] = !tx_full[n];
            sr[rf_pos(n)] = rx_full[n];
            sr[gp_pos(n)] = gip_q[n];
            cr[te_pos(n)] = tie[n];
            cr[rf_pos(n)] = rie[n];
            cr[gp_pos(n)] = gie[n];
            cr[gr_pos(n)] = gir_q[n];
        end
    end

    // Read data mux; outgoing slots and unmapped words read as zero.
    always_comb begin
        rdata = '0;
        if (hit && !write) begin
            if (widx == IW'(WIDX_SR))      rdata = sr;
            else if (widx == IW'(WIDX_CR)) rdata = cr;
            else begin
                for (int n = 0; n < CH; n++)
                    if (widx == IW'(WIDX_RX0 + n)) rdata = rx_data[n];
            end
        end
    end

    // Interrupt: OR of every enabled source.
    assign irq = |((~tx_full & tie) | (rx_full & rie) | (gip_q & gie));

    assert_no_enable_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tie == '0 && rie == '0 && gie == '0) |-> !irq);
    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tx_wr == '0 && rx_rd == '0 && gir_set == '0 && gip_ack == '0));
    assert_enables_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (tie == '0 && rie == '0 && gie == '0));
endmodule

// File: rtl/ipc_msg_unit.sv
// Top of the messaging unit. It joins two register ports through CH data
// channels and CH doorbells in each direction, plus a shared soft-reset
// sequencer. One clock domain is assumed for both sides.
module ipc_msg_unit
    import ipc_mu_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 6,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic          a_write,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic          b_valid,
    input  logic          b_write,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic                  busy;
    logic                  a_rst_req, b_rst_req;
    logic [CH-1:0]         a_tx_wr, a_rx_rd, a_gir_set, a_gip_ack;
    logic [CH-1:0]         b_tx_wr, b_rx_rd, b_gir_set, b_gip_ack;
    logic [CH-1:0]         ab_full, ba_full, ab_bell, ba_bell;
    logic [CH-1:0][DW-1:0] ab_data, ba_data;

    ipc_mu_rstseq #(.CYC(RST_CYCLES)) u_rstseq (
        .clk(clk), .rst_n(rst_n), .start(a_rst_req || b_rst_req), .busy(busy)
    );

    ipc_mu_side #(.DW(DW), .AW(AW)) u_side_a (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .valid(a_valid), .write(a_write), .addr(a_addr), .wdata(a_wdata),
        .rdata(a_rdata), .irq(a_irq),
        .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .gir_set(a_gir_set), .gip_ack(a_gip_ack),
        .rst_req(a_rst_req),
        .tx_full(ab_full), .rx_full(ba_full), .rx_data(ba_data),
        .gir_q(ab_bell), .gip_q(ba_bell)
    );

    ipc_mu_side #(.DW(DW), .AW(AW)) u_side_b (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .valid(b_valid), .write(b_write), .addr(b_addr), .wdata(b_wdata),
        .rdata(b_rdata), .irq(b_irq),
        .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .gir_set(b_gir_set), .gip_ack(b_gip_ack),
        .rst_req(b_rst_req),
        .tx_full(ba_full), .rx_full(ab_full), .rx_data(ab_data),
        .gir_q(ba_bell), .gip_q(ab_bell)
    );

    for (genvar n = 0; n < CH; n++) begin : g_link
        ipc_mu_chan #(.DW(DW)) u_ab (
            .clk(clk), .rst_n(rst_n), .clr(busy), .wr(a_tx_wr[n]), .wdata(a_wdata),
            .rd(b_rx_rd[n]), .full(ab_full[n]), .data(ab_data[n])
        );
        ipc_mu_chan #(.DW(DW)) u_ba (
            .clk(clk), .rst_n(rst_n), .clr(busy), .wr(b_tx_wr[n]), .wdata(b_wdata),
            .rd(a_rx_rd[n]), .full(ba_full[n]), .data(ba_data[n])
        );
        ipc_mu_bell u_bell_ab (
            .clk(clk), .rst_n(rst_n), .clr(busy), .req(a_gir_set[n]),
            .ack(b_gip_ack[n]), .pend(ab_bell[n])
        );
        ipc_mu_bell u_bell_ba (
            .clk(clk), .rst_n(rst_n), .clr(busy), .req(b_gir_set[n]),
            .ack(a_gip_ack[n]), .pend(ba_bell[n])
        );
    end
endmodule

// File: tb/ipc_msg_unit_tb.sv
// Bench for the messaging unit: directed corner cases followed by seeded
// random traffic, compared against a flag model kept in the bench.
module ipc_msg_unit_tb_top;
    localparam int RSTC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_valid = 1'b0, a_write = 1'b0, b_valid = 1'b0, b_write = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int fails  = 0;

    // Model: index s is the sending/owning side (0 = A, 1 = B).
    bit          m_full [2][4];
    logic [31:0] m_dat  [2][4];
    bit          m_gir  [2][4];
    bit   [3:0]  m_tie [2], m_rie [2], m_gie [2];

    always #4 clk = ~clk;   // 125 MHz

    ipc_msg_unit #(.RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_write(a_write), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_valid(b_valid), .b_write(b_write), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < 4; n++) begin
                m_full[s][n] = 0; m_dat[s][n] = '0; m_gir[s][n] = 0;
            end
            m_tie[s] = '0; m_rie[s] = '0; m_gie[s] = '0;
        end
    endtask

    function automatic logic [31:0] exp_sr(input int s, input bit busy);
        logic [31:0] v = '0;
        v[7] = busy;
        for (int n = 0; n < 4; n++) begin
            v[23-n] = !m_full[s][n];
            v[27-n] = m_full[1-s][n];
            v[31-n] = m_gir[1-s][n];
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_cr(input int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[23-n] = m_tie[s][n];
            v[27-n] = m_rie[s][n];
            v[31-n] = m_gie[s][n];
            v[19-n] = m_gir[s][n];
        end
        return v;
    endfunction

    function automatic bit exp_irq(input int s);
        bit r = 0;
        for (int n = 0; n < 4; n++)
            r |= (!m_full[s][n] && m_tie[s][n]) || (m_full[1-s][n] && m_rie[s][n])
                 || (m_gir[1-s][n] && m_gie[s][n]);
        return r;
    endfunction

    task automatic mdl_write(input int s, input logic [5:0] ad, input logic [31:0] d);
        int idx = int'(ad[5:2]);
        if (ad[1:0] != 2'b00) return;
        if (idx < 4) begin
            m_dat[s][idx] = d; m_full[s][idx] = 1;
        end else if (idx == 8) begin
            for (int n = 0; n < 4; n++) if (d[31-n]) m_gir[1-s][n] = 0;
        end else if (idx == 9) begin
            if (d[5]) mdl_clear();
            else for (int n = 0; n < 4; n++) begin
                m_tie[s][n] = d[23-n]; m_rie[s][n] = d[27-n]; m_gie[s][n] = d[31-n];
                if (d[19-n]) m_gir[s][n] = 1;
            end
        end
    endtask

    task automatic mdl_read(input int s, input logic [5:0] ad);
        int idx = int'(ad[5:2]);
        if (ad[1:0] == 2'b00 && idx >= 4 && idx < 8) m_full[1-s][idx-4] = 0;
    endtask

    task automatic idle();
        a_valid = 0; b_valid = 0; a_write = 0; b_write = 0;
    endtask

    task automatic drive(input int s, input bit w, input logic [5:0] ad, input logic [31:0] d);
        if (s == 0) begin a_valid = 1; a_write = w; a_addr = ad; a_wdata = d; end
        else        begin b_valid = 1; b_write = w; b_addr = ad; b_wdata = d; end
    endtask

    // One access spanning one rising edge; read data sampled before the edge.
    task automatic access(input int s, input bit w, input logic [5:0] ad,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        drive(s, w, ad, d);
        #1 rd = (s == 0) ? a_rdata : b_rdata;
        @(posedge clk);
        #1 idle();
        if (w) mdl_write(s, ad, d); else mdl_read(s, ad);
    endtask

    task automatic wr(input int s, input logic [5:0] ad, input logic [31:0] d);
        logic [31:0] junk;
        access(s, 1'b1, ad, d, junk);
    endtask

    task automatic rd_chk(input int s, input logic [5:0] ad, input logic [31:0] exp,
                          input string req);
        logic [31:0] v;
        access(s, 1'b0, ad, 32'h0, v);
        chk(req, v, exp);
    endtask

    task automatic chk_state(input string req);
        rd_chk(0, 6'h20, exp_sr(0, 0), req);
        rd_chk(1, 6'h20, exp_sr(1, 0), req);
        rd_chk(0, 6'h24, exp_cr(0), req);
        rd_chk(1, 6'h24, exp_cr(1), req);
        @(negedge clk);
        chk({req, " irqA"}, {31'b0, a_irq}, {31'b0, exp_irq(0)});
        chk({req, " irqB"}, {31'b0, b_irq}, {31'b0, exp_irq(1)});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd20240611));
        mdl_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_state("R1 reset");
        chk("R1 sr literal", exp_sr(0, 0), 32'h00F00000);

        // R2: A -> B slot 2
        wr(0, 6'h08, 32'hCAFE0002);
        rd_chk(0, 6'h20, exp_sr(0, 0), "R2 A te cleared");
        rd_chk(1, 6'h20, exp_sr(1, 0), "R2 B rf set");
        // R3: read drains and re-arms
        rd_chk(1, 6'h18, 32'hCAFE0002, "R3 B reads data");
        chk_state("R3 after read");

        // R4: B -> A slot 0 and slot 3 independent
        wr(1, 6'h00, 32'h11110000);
        wr(1, 6'h0C, 32'h33330003);
        rd_chk(0, 6'h20, exp_sr(0, 0), "R4 A sees two words");
        rd_chk(0, 6'h1C, 32'h33330003, "R4 A reads slot3");
        chk_state("R4 slot0 still present");

        // R3: same-cycle write and read on channel A->B 1, write wins
        wr(0, 6'h04, 32'h0000AAAA);
        @(negedge clk);
        drive(0, 1'b1, 6'h04, 32'h0000BBBB);
        drive(1, 1'b0, 6'h14, 32'h0);
        #1 chk("R3 collision old data", b_rdata, 32'h0000AAAA);
        @(posedge clk);
        #1 idle();
        m_dat[0][1] = 32'h0000BBBB; m_full[0][1] = 1;
        chk_state("R3 write wins");
        rd_chk(1, 6'h14, 32'h0000BBBB, "R3 new word kept");

        // R5: doorbell from A, bit 19-n with n=1 -> bit 18
        wr(0, 6'h24, 32'h00040000);
        chk_state("R5 ring");
        wr(0, 6'h24, 32'h00000000);
        chk_state("R5 zero keeps request");
        // R6: zero ack no effect, then one clears
        wr(1, 6'h20, 32'h00000000);
        chk_state("R6 zero ack");
        wr(1, 6'h20, 32'h40000000);
        chk_state("R6 ack clears");

        // R7: enables
        wr(1, 6'h24, 32'h40000000);   // B: GIE n=1
        chk_state("R7 gie no pend");
        wr(0, 6'h24, 32'h00040000);   // ring again
        chk_state("R7 gie pend irq");
        wr(0, 6'h24, 32'h00800000);   // A: TIE n=0, empty -> irq
        chk_state("R7 tie");
        wr(0, 6'h00, 32'h5);          // slot0 full -> no TE irq
        chk_state("R7 tie drop");

        // R10: ignored writes
        wr(0, 6'h10, 32'hFFFFFFFF);
        wr(0, 6'h20, 32'h0FFFFFFF);
        wr(1, 6'h01, 32'hFFFFFFFF);
        wr(1, 6'h25, 32'hFFFFFFFF);
        chk_state("R10 ignored");
        rd_chk(0, 6'h04, 32'h0, "R10 tx reads zero");

        // R8/R9: soft reset from B with state present
        wr(1, 6'h24, 32'hFFFFFFFF);
        mdl_clear();
        for (int k = 1; k <= RSTC; k++) begin
            @(negedge clk);
            drive(1, 1'b0, 6'h20, 32'h0);
            if (k == 2) drive(0, 1'b1, 6'h0C, 32'hDEAD0000);
            #1;
            chk("R8 busy B", {31'b0, b_rdata[7]}, 32'h1);
            @(posedge clk);
            #1 idle();
        end
        @(negedge clk);
        drive(0, 1'b0, 6'h20, 32'h0);
        #1 chk("R8 busy ends", a_rdata, exp_sr(0, 0));
        @(posedge clk);
        #1 idle();
        chk_state("R9 post reset");
        rd_chk(1, 6'h1C, 32'h0, "R8 data cleared");
        rd_chk(1, 6'h1C, 32'h0, "R9 write during busy dropped");

        // Random traffic on both sides
        for (int it = 0; it < 600; it++) begin
            int s   = int'($urandom % 2);
            int op  = int'($urandom % 7);
            int n   = int'($urandom % 4);
            logic [31:0] d = $urandom;
            case (op)
                0, 1: wr(s, 6'(n * 4), d);
                2:    rd_chk(s, 6'(16 + n * 4), m_dat[1-s][n], "R2 random data");
                3:    rd_chk(s, 6'h20, exp_sr(s, 0), "R4 random status");
                4:    wr(s, 6'h24, d & 32'hFFFFFFDF);
                5:    wr(s, 6'h20, d);
                default: rd_chk(s, 6'h24, exp_cr(s), "R5 random control");
            endcase
            @(negedge clk);
            chk("R7 random irqA", {31'b0, a_irq}, {31'b0, exp_irq(0)});
            chk("R7 random irqB", {31'b0, b_irq}, {31'b0, exp_irq(1)});
        end
        chk_state("R6 random end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule